// File: doc/BRIEF.md
# Source Pixel Unpacker to 32-bit ARGB

This block takes one source pixel at a time, together with the settings that describe how to read it, and returns the same pixel as a 32-bit word with 8-bit alpha, red, green and blue fields. It sits at the front of a 2-D graphics pipeline. Every fetched source word passes through it, so the stages after it only ever see one uniform format.

Eleven source layouts are understood. Five are packed true-colour formats, four are indexed (luminance) formats that read a colour table through a simple lookup port, and two carry only alpha and take their colour from a programmed constant. After unpacking, an alpha policy keeps, replaces or scales the alpha. An optional inversion is then applied to the final alpha, and red and blue can be exchanged so that BGR-ordered data is accepted. The settings are sampled together with each pixel.

The control is a four-state machine:
- `ST_IDLE` accepts a pixel. A direct format moves to `ST_EMIT`. An indexed format moves to `ST_FETCH`. A bad mode code stays in `ST_IDLE` and raises the error pulse.
- `ST_FETCH` issues the table read and always moves to `ST_CATCH`.
- `ST_CATCH` captures the table word and moves to `ST_EMIT`.
- `ST_EMIT` presents the result and returns to `ST_IDLE` when the consumer takes it.

Top module: `pix_unpack`

## Requirements
- R1: Packed modes widen each field to 8 bits by bit replication, with the pixel LSB-aligned in `in_pixel`:
  - mode 0: A[31:24] R[23:16] G[15:8] B[7:0].
  - mode 1: R[23:16] G[15:8] B[7:0], alpha 255.
  - mode 2: R[15:11] G[10:5] B[4:0], alpha 255. A 5-bit field x becomes {x,x[4:2]}; a 6-bit field x becomes {x,x[5:4]}.
  - mode 3: A[15] R[14:10] G[9:5] B[4:0]. The 1-bit alpha becomes 0 or 255.
  - mode 4: A[15:12] R[11:8] G[7:4] B[3:0]. Each 4-bit field becomes its value times 17.
- R2: Mode 9 takes alpha from bits [7:0]. Mode 10 takes alpha from bits [3:0] times 17. In both modes red, green and blue come from `in_fixrgb`, with red in [23:16], green in [15:8] and blue in [7:0].
- R3: Indexed modes read the table at the index given by the pixel:
  - mode 5 uses bits [7:0] as the index, and alpha comes from the entry.
  - mode 8 uses bits [3:0] as the index, and alpha comes from the entry.
  - mode 6 uses bits [3:0] as the index, and alpha is bits [7:4] times 17.
  - mode 7 uses bits [7:0] as the index, and alpha is bits [15:8].
- R4: A table entry is read as ARGB8888 when `tbl_fmt` is 0. When `tbl_fmt` is 1 it is read as RGB888, with alpha 255. The table holds `tbl_last`+1 entries. An index above `tbl_last` issues no read and uses the entry value 0x00000000.
- R5: Alpha policy code 0 keeps the alpha, and code 3 also keeps it. Code 1 replaces the alpha with `in_alpha`. Code 2 sets the alpha to round(alpha × `in_alpha` / 255).
- R6: When `in_ainv` is 1, the alpha produced by the policy is replaced by its one's complement.
- R7: When `in_rbswap` is 1, the red and blue output fields are exchanged.
- R8: A colour mode code of 11 to 15 produces no output. `cfg_err` is high for exactly the one cycle after the pixel is accepted.
- R9: A direct-format result becomes valid 1 cycle after acceptance, and an indexed-format result 3 cycles after. While `out_ready` is low, `out_valid` and `out_argb` hold. `in_ready` is high only in `ST_IDLE`.
- R10: For an indexed pixel whose index is in range, `lut_rd` is high for one cycle, the cycle after acceptance, with `lut_addr` equal to the index. `lut_data` is expected one cycle after `lut_rd`.
- R11: After reset, `in_ready` is 1 and `out_valid`, `lut_rd` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Source pixel and settings present |
| in_ready | output | 1 | Block can accept a pixel |
| in_pixel | input | 32 | Source pixel, LSB-aligned |
| in_cmode | input | 4 | Source colour mode code |
| in_amode | input | 2 | Alpha policy code |
| in_alpha | input | 8 | Fixed alpha for replace and scale |
| in_fixrgb | input | 24 | Constant colour for alpha-only modes |
| in_ainv | input | 1 | Invert final alpha |
| in_rbswap | input | 1 | Exchange red and blue |
| tbl_fmt | input | 1 | Table entry format (0 ARGB8888, 1 RGB888) |
| tbl_last | input | 8 | Highest valid table index |
| lut_rd | output | 1 | Table read strobe |
| lut_addr | output | 8 | Table read index |
| lut_data | input | 32 | Table word, one cycle after the strobe |
| out_valid | output | 1 | Converted pixel present |
| out_ready | input | 1 | Consumer takes the pixel |
| out_argb | output | 32 | Converted pixel, A[31:24] R G B[7:0] |
| cfg_err | output | 1 | One-cycle pulse for a bad mode code |

## Verification
Each result is due at a fixed distance from the acceptance edge:
- a direct-format pixel shows `out_valid` at the first falling edge after acceptance;
- an indexed pixel shows its table strobe at that first falling edge and its result at the third;
- a bad mode code shows `cfg_err` at the first falling edge and clears it by the second.

The driver counts falling edges from acceptance and compares the count with these figures. A separate monitor compares each value taken by the consumer against the queued prediction, and a periodic back-pressure pattern checks that a stalled result does not change.

// File: rtl/pix_pkg.sv
package pix_pkg;
    localparam int CH_W   = 8;
    localparam int PIX_W  = 4 * CH_W;
    localparam int RGB_W  = 3 * CH_W;
    localparam int IDX_W  = 8;
    localparam int CM_W   = 4;
    localparam int AM_W   = 2;
    localparam int PROD_W = 2 * CH_W + 1;

    typedef enum logic [CM_W-1:0] {
        CM_ARGB8888 = 4'd0,
        CM_RGB888   = 4'd1,
        CM_RGB565   = 4'd2,
        CM_ARGB1555 = 4'd3,
        CM_ARGB4444 = 4'd4,
        CM_L8       = 4'd5,
        CM_AL44     = 4'd6,
        CM_AL88     = 4'd7,
        CM_L4       = 4'd8,
        CM_A8       = 4'd9,
        CM_A4       = 4'd10
    } cmode_e;

    typedef enum logic [AM_W-1:0] {
        AM_KEEP    = 2'd0,
        AM_REPLACE = 2'd1,
        AM_SCALE   = 2'd2,
        AM_SPARE   = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CATCH,
        ST_EMIT
    } state_e;

    typedef struct packed {
        logic [CH_W-1:0] a;
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } argb_t;

    function automatic logic [CH_W-1:0] widen1(input logic x);
        return {CH_W{x}};
    endfunction

    function automatic logic [CH_W-1:0] widen4(input logic [3:0] x);
        return {x, x};
    endfunction

    function automatic logic [CH_W-1:0] widen5(input logic [4:0] x);
        return {x, x[4:2]};
    endfunction

    function automatic logic [CH_W-1:0] widen6(input logic [5:0] x);
        return {x, x[5:4]};
    endfunction
endpackage

// File: rtl/pix_decode.sv
module pix_decode
    import pix_pkg::*;
(
    input  logic [PIX_W-1:0] pixel,
    input  logic [CM_W-1:0]  cmode,
    input  logic [RGB_W-1:0] fixrgb,
    output argb_t            direct,
    output logic             mode_ok,
    output logic             is_idx,
    output logic [IDX_W-1:0] idx,
    output logic             own_alpha,
    output logic [CH_W-1:0]  pix_alpha
);
    always_comb begin
        direct    = '0;
        direct.a  = '1;
        mode_ok   = 1'b1;
        is_idx    = 1'b0;
        idx       = '0;
        own_alpha = 1'b0;
        pix_alpha = '0;
        case (cmode)
            CM_ARGB8888: direct = pixel;
            CM_RGB888:   direct = {8'hFF, pixel[23:0]};
            CM_RGB565: begin
                direct.r = widen5(pixel[15:11]);
                direct.g = widen6(pixel[10:5]);
                direct.b = widen5(pixel[4:0]);
            end
            CM_ARGB1555: begin
                direct.a = widen1(pixel[15]);
                direct.r = widen5(pixel[14:10]);
                direct.g = widen5(pixel[9:5]);
                direct.b = widen5(pixel[4:0]);
            end
            CM_ARGB4444: begin
                direct.a = widen4(pixel[15:12]);
                direct.r = widen4(pixel[11:8]);
                direct.g = widen4(pixel[7:4]);
                direct.b = widen4(pixel[3:0]);
            end
            CM_L8: begin
                is_idx = 1'b1;
                idx    = pixel[7:0];
            end
            CM_AL44: begin
                is_idx    = 1'b1;
                idx       = {4'b0, pixel[3:0]};
                own_alpha = 1'b1;
                pix_alpha = widen4(pixel[7:4]);
            end
            CM_AL88: begin
                is_idx    = 1'b1;
                idx       = pixel[7:0];
                own_alpha = 1'b1;
                pix_alpha = pixel[15:8];
            end
            CM_L4: begin
                is_idx = 1'b1;
                idx    = {4'b0, pixel[3:0]};
            end
            CM_A8: direct = {pixel[7:0], fixrgb};
            CM_A4: direct = {widen4(pixel[3:0]), fixrgb};
            default: mode_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/pix_lutmap.sv
module pix_lutmap
    import pix_pkg::*;
(
    input  logic [PIX_W-1:0] entry,
    input  logic             tfmt,
    input  logic             hit,
    input  logic             own_alpha,
    input  logic [CH_W-1:0]  pix_alpha,
    output argb_t            px
);
    always_comb begin
        px = hit ? argb_t'(entry) : '0;
        if (hit && tfmt) begin
            px.a = '1;
        end
        if (own_alpha) begin
            px.a = pix_alpha;
        end
    end
endmodule

// File: rtl/pix_alpha.sv
module pix_alpha
    import pix_pkg::*;
(
    input  argb_t            px_in,
    input  logic [AM_W-1:0]  amode,
    input  logic [CH_W-1:0]  fix_alpha,
    input  logic             inv,
    input  logic             swap,
    output argb_t            px_out
);
    logic [PROD_W-1:0] prod_raw;
    logic [CH_W-1:0]   scaled;
    logic [CH_W-1:0]   pol_alpha;

    always_comb begin
        prod_raw = PROD_W'(px_in.a) * PROD_W'(fix_alpha) + PROD_W'(128);
        scaled   = CH_W'((prod_raw + (prod_raw >> CH_W)) >> CH_W);
        case (amode)
            AM_REPLACE: pol_alpha = fix_alpha;
            AM_SCALE:   pol_alpha = scaled;
            default:    pol_alpha = px_in.a;
        endcase
        px_out.a = inv ? ~pol_alpha : pol_alpha;
        px_out.g = px_in.g;
        px_out.r = swap ? px_in.b : px_in.r;
        px_out.b = swap ? px_in.r : px_in.b;
    end

    always_comb begin
        if (amode == AM_SCALE && fix_alpha == 8'hFF && !inv) begin
            // R5
            scale_unity_chk: assert (px_out.a == px_in.a);
        end
    end
endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
    import pix_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [31:0]      in_pixel,
    input  logic [3:0]       in_cmode,
    input  logic [1:0]       in_amode,
    input  logic [7:0]       in_alpha,
    input  logic [23:0]      in_fixrgb,
    input  logic             in_ainv,
    input  logic             in_rbswap,
    input  logic             tbl_fmt,
    input  logic [7:0]       tbl_last,
    output logic             lut_rd,
    output logic [7:0]       lut_addr,
    input  logic [31:0]      lut_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [31:0]      out_argb,
    output logic             cfg_err
);
    state_e state_q, state_d;

    logic [AM_W-1:0]  amode_q;
    logic [CH_W-1:0]  falpha_q;
    logic             inv_q, swap_q, tfmt_q;
    logic [IDX_W-1:0] idx_q;
    logic             hit_q, own_q;
    logic [CH_W-1:0]  palpha_q;
    argb_t            res_q;
    logic             err_q;

    argb_t            dec_px, lut_px, pol_in, pol_out;
    logic             mode_ok, is_idx, own_alpha;
    logic [IDX_W-1:0] idx;
    logic [CH_W-1:0]  pix_alpha;
    logic             accept, use_lut;
    logic [AM_W-1:0]  sel_amode;
    logic [CH_W-1:0]  sel_alpha;
    logic             sel_inv, sel_swap;

    assign accept  = in_valid && (state_q == ST_IDLE);
    assign use_lut = (state_q == ST_CATCH);

    pix_decode u_dec (
        .pixel     (in_pixel),
        .cmode     (in_cmode),
        .fixrgb    (in_fixrgb),
        .direct    (dec_px),
        .mode_ok   (mode_ok),
        .is_idx    (is_idx),
        .idx       (idx),
        .own_alpha (own_alpha),
        .pix_alpha (pix_alpha)
    );

    pix_lutmap u_map (
        .entry     (lut_data),
        .tfmt      (tfmt_q),
        .hit       (hit_q),
        .own_alpha (own_q),
        .pix_alpha (palpha_q),
        .px        (lut_px)
    );

    always_comb begin
        pol_in    = use_lut ? lut_px   : dec_px;
        sel_amode = use_lut ? amode_q  : in_amode;
        sel_alpha = use_lut ? falpha_q : in_alpha;
        sel_inv   = use_lut ? inv_q    : in_ainv;
        sel_swap  = use_lut ? swap_q   : in_rbswap;
    end

    pix_alpha u_alpha (
        .px_in     (pol_in),
        .amode     (sel_amode),
        .fix_alpha (sel_alpha),
        .inv       (sel_inv),
        .swap      (sel_swap),
        .px_out    (pol_out)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && mode_ok) state_d = is_idx ? ST_FETCH : ST_EMIT;
            end
            ST_FETCH: state_d = ST_CATCH;
            ST_CATCH: state_d = ST_EMIT;
            ST_EMIT:  if (out_ready) state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            amode_q  <= '0;
            falpha_q <= '0;
            inv_q    <= 1'b0;
            swap_q   <= 1'b0;
            tfmt_q   <= 1'b0;
            idx_q    <= '0;
            hit_q    <= 1'b0;
            own_q    <= 1'b0;
            palpha_q <= '0;
            res_q    <= '0;
            err_q    <= 1'b0;
        end else begin
            err_q <= accept && !mode_ok;
            if (accept) begin
                amode_q  <= in_amode;
                falpha_q <= in_alpha;
                inv_q    <= in_ainv;
                swap_q   <= in_rbswap;
                tfmt_q   <= tbl_fmt;
                idx_q    <= idx;
                hit_q    <= (idx <= tbl_last);
                own_q    <= own_alpha;
                palpha_q <= pix_alpha;
            end
            if ((accept && mode_ok && !is_idx) || use_lut) begin
                res_q <= pol_out;
            end
        end
    end

    // outputs
    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        lut_rd    = (state_q == ST_FETCH) && hit_q;
        lut_addr  = idx_q;
        out_valid = (state_q == ST_EMIT);
        out_argb  = res_q;
        cfg_err   = err_q;
    end

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_argb));

    // R10
    lut_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lut_rd |=> !lut_rd);

    // R10
    lut_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lut_rd |-> ##2 out_valid);

    // R8
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !out_valid);
endmodule

// File: tb/pix_unpack_test.sv
module pix_unpack_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_pixel;
    logic [3:0]  in_cmode;
    logic [1:0]  in_amode;
    logic [7:0]  in_alpha;
    logic [23:0] in_fixrgb;
    logic        in_ainv, in_rbswap, tbl_fmt;
    logic [7:0]  tbl_last;
    logic        lut_rd;
    logic [7:0]  lut_addr;
    logic [31:0] lut_data;
    logic        out_valid, out_ready;
    logic [31:0] out_argb;
    logic        cfg_err;

    always #10 clk = ~clk;

    pix_unpack uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_pixel(in_pixel), .in_cmode(in_cmode), .in_amode(in_amode),
        .in_alpha(in_alpha), .in_fixrgb(in_fixrgb), .in_ainv(in_ainv),
        .in_rbswap(in_rbswap), .tbl_fmt(tbl_fmt), .tbl_last(tbl_last),
        .lut_rd(lut_rd), .lut_addr(lut_addr), .lut_data(lut_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_argb(out_argb),
        .cfg_err(cfg_err)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit stall  = 0;
    string cur_req = "R1";
    logic [31:0] exp_q[$];
    logic [31:0] tbl [256];

    task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++)
            tbl[i] = {8'(i * 7 + 1), 8'(i), 8'(255 - i), 8'(i + 51)};
    end

    always @(posedge clk) if (lut_rd) lut_data <= tbl[lut_addr];

    // back-pressure pattern
    initial begin
        out_ready = 1'b1;
        forever begin
            @(posedge clk);
            #2;
            cyc++;
            out_ready = !stall || (cyc % 3 == 0);
        end
    end

    // monitor
    bit          held = 0;
    logic [31:0] held_v;
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (held) begin
                chk(out_valid && out_argb == held_v, "R9 hold", out_argb, held_v);
                held = 0;
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) chk(0, "R9 spurious output", out_argb, 32'h0);
                else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(out_argb == e, cur_req, out_argb, e);
                end
            end else if (out_valid) begin
                held   = 1;
                held_v = out_argb;
            end
        end
    end

    function automatic logic [31:0] model(input logic [31:0] p, input int cm,
                                          output bit indexed, output bit hit, output logic [7:0] ix);
        int a, r, g, b;
        logic [31:0] e;
        indexed = 0; hit = 0; ix = 0;
        a = 255; r = 0; g = 0; b = 0;
        case (cm)
            0: begin a = p[31:24]; r = p[23:16]; g = p[15:8]; b = p[7:0]; end
            1: begin r = p[23:16]; g = p[15:8]; b = p[7:0]; end
            2: begin
                r = (int'(p[15:11]) << 3) | (int'(p[15:11]) >> 2);
                g = (int'(p[10:5]) << 2) | (int'(p[10:5]) >> 4);
                b = (int'(p[4:0]) << 3) | (int'(p[4:0]) >> 2);
            end
            3: begin
                a = p[15] ? 255 : 0;
                r = (int'(p[14:10]) << 3) | (int'(p[14:10]) >> 2);
                g = (int'(p[9:5]) << 3) | (int'(p[9:5]) >> 2);
                b = (int'(p[4:0]) << 3) | (int'(p[4:0]) >> 2);
            end
            4: begin
                a = p[15:12] * 17; r = p[11:8] * 17; g = p[7:4] * 17; b = p[3:0] * 17;
            end
            5, 6, 7, 8: begin
                indexed = 1;
                ix  = (cm == 6 || cm == 8) ? {4'b0, p[3:0]} : p[7:0];
                hit = (ix <= tbl_last);
                e   = hit ? tbl[ix] : 32'h0;
                a   = (hit && tbl_fmt) ? 255 : e[31:24];
                r = e[23:16]; g = e[15:8]; b = e[7:0];
                if (cm == 6) a = p[7:4] * 17;
                if (cm == 7) a = p[15:8];
            end
            9:  begin a = p[7:0]; r = in_fixrgb[23:16]; g = in_fixrgb[15:8]; b = in_fixrgb[7:0]; end
            default: begin a = p[3:0] * 17; r = in_fixrgb[23:16]; g = in_fixrgb[15:8]; b = in_fixrgb[7:0]; end
        endcase
        if (in_amode == 1) a = in_alpha;
        else if (in_amode == 2) a = (a * in_alpha * 2 + 255) / 510;
        if (in_ainv) a = 255 - a;
        if (in_rbswap) begin int t; t = r; r = b; b = t; end
        return {8'(a), 8'(r), 8'(g), 8'(b)};
    endfunction

    task automatic send(input logic [31:0] p, input int cm, input string req);
        bit indexed, hit;
        logic [7:0] ix;
        logic [31:0] e;
        int lat;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_pixel = p;
        in_cmode = 4'(cm);
        in_valid = 1'b1;
        cur_req  = req;
        if (cm > 10) begin
            @(negedge clk);
            in_valid = 1'b0;
            chk(cfg_err == 1'b1 && out_valid == 1'b0, "R8 error pulse", {30'b0, cfg_err, out_valid}, 32'h2);
            @(negedge clk);
            chk(cfg_err == 1'b0 && out_valid == 1'b0, "R8 pulse ends, no output", {30'b0, cfg_err, out_valid}, 32'h0);
        end else begin
            e = model(p, cm, indexed, hit, ix);
            exp_q.push_back(e);
            @(negedge clk);
            in_valid = 1'b0;
            lat = 1;
            if (indexed) begin
                chk(lut_rd == hit, "R10 read strobe", {31'b0, lut_rd}, {31'b0, hit});
                if (hit) chk(lut_addr == ix, "R10 read index", {24'b0, lut_addr}, {24'b0, ix});
                else     chk(lut_rd == 1'b0, "R4 no read out of range", {31'b0, lut_rd}, 32'h0);
            end
            while (!out_valid && lat < 10) begin @(negedge clk); lat++; end
            chk(lat == (indexed ? 3 : 1), "R9 latency", lat, indexed ? 3 : 1);
        end
    endtask

    task automatic cfg(input int am, input logic [7:0] fa, input bit inv, input bit sw);
        in_amode = 2'(am); in_alpha = fa; in_ainv = inv; in_rbswap = sw;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog: got hang expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_pixel = '0; in_cmode = '0;
        in_fixrgb = 24'h102030; tbl_fmt = 1'b0; tbl_last = 8'hFF;
        cfg(0, 8'h00, 0, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        chk(in_ready == 1'b1 && out_valid == 1'b0 && lut_rd == 1'b0 && cfg_err == 1'b0,
            "R11 reset", {28'b0, in_ready, out_valid, lut_rd, cfg_err}, 32'h8);
        rst_n = 1'b1;

        send(32'h80112233, 0, "R1 argb8888");
        send(32'hAB123456, 1, "R1 rgb888");
        send(32'h0000F81F, 2, "R1 rgb565");
        send(32'h00001234, 2, "R1 rgb565 b");
        send(32'h00007C00, 3, "R1 argb1555");
        send(32'h000083E0, 3, "R1 argb1555 b");
        send(32'h00005A3C, 4, "R1 argb4444");
        send(32'h00000040, 9, "R2 a8");
        send(32'h00000009, 10, "R2 a4");
        send(32'h00000005, 5, "R3 l8");
        send(32'h0000007E, 6, "R3 al44");
        send(32'h00003344, 7, "R3 al88");
        tbl_fmt = 1'b1;
        send(32'h0000000C, 8, "R4 l4 rgb888 entry");
        send(32'h000000C8, 5, "R4 l8 rgb888 entry");
        tbl_fmt = 1'b0; tbl_last = 8'h0F;
        send(32'h00000090, 5, "R4 out of range");
        send(32'h0000550F, 7, "R4 last entry");
        send(32'h00005510, 7, "R4 past last entry");
        tbl_last = 8'hFF;
        cfg(1, 8'h3C, 0, 0); send(32'h80112233, 0, "R5 replace");
        cfg(2, 8'h80, 0, 0); send(32'h80112233, 0, "R5 scale");
        cfg(2, 8'hFF, 0, 0); send(32'h7F112233, 0, "R5 scale unity");
        cfg(2, 8'h00, 0, 0); send(32'h00000009, 10, "R5 scale zero");
        cfg(3, 8'h11, 0, 0); send(32'h42112233, 0, "R5 spare code keeps");
        cfg(0, 8'h00, 1, 0); send(32'h80112233, 0, "R6 invert");
        cfg(2, 8'h80, 1, 0); send(32'hC0112233, 0, "R6 invert after scale");
        cfg(0, 8'h00, 0, 1); send(32'h80112233, 0, "R7 swap");
        cfg(0, 8'h00, 0, 1); send(32'h00000005, 5, "R7 swap indexed");
        cfg(0, 8'h00, 0, 0);
        send(32'h00000000, 11, "R8");
        send(32'h00000000, 15, "R8");
        send(32'h00ABCDEF, 1, "R8 recovery");

        stall = 1;
        for (int cm = 0; cm <= 10; cm++) begin
            for (int k = 0; k < 6; k++) begin
                logic [31:0] p;
                p = 32'h9E3779B9 * (k + 1) + cm;
                cfg(k % 4, 8'(k * 53 + 7), k[0], k[1]);
                tbl_fmt = k[2];
                send(p, cm, "R1 R3 R5 R9 sweep");
            end
        end
        stall = 0;
        cfg(0, 8'h00, 0, 0);

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all outputs delivered", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule